// File: doc/BRIEF.md
# Converter Input Multiplexer Select Logic

This block drives the address lines of three analog multiplexers. Their outputs are summed into the input of a single successive-approximation converter. The three multiplexers are time-shared: only one carries signal at any moment. The other two are parked on address 0, which is wired to ground or to a small reference, so they add nothing to the sum. Two of the multiplexers are 1-of-8 parts that serve the pulse-height detectors, one part for each detector. The third is a 4-input part that serves the precision current-monitor channels.

A mode level chooses between pulse-height work and precision work. A detector-select level chooses which 1-of-8 part is live in pulse mode. A calibrate level moves the live part to its lower address half, where the calibration points are wired. Two channel-count bits, A and B, step through four readouts. The 4-input part sees only A, so it scans its two points twice in one four-step sweep.

All addresses and the reported result width are captured together on the channel-advance strobe. They then hold until the next strobe. The multiplexer power enable follows the converter-active level one clock later.

Top module: `adc_mux_sel`

## Requirements
- R1: After reset, all three addresses are 0, the power enable is low, and the reported result width is 10.
- R2: On a strobe with the mode level high (pulse mode), the 4-input address becomes 0. If detector-select is high, the second 1-of-8 address becomes 0 and the first carries the channel. If detector-select is low, the first becomes 0 and the second carries the channel.
- R3: On a strobe with the mode level low (precision mode), both 1-of-8 addresses become 0 whatever detector-select is, and the 4-input address carries the channel.
- R4: The live address has its top bit cleared when the calibrate level is high. This is bit 2 of a 1-of-8 address, which gives inputs 0 to 3, and bit 1 of the 4-input address, which gives inputs 0 and 1. The top bit is set when the calibrate level is low, which gives inputs 4 to 7 and inputs 2 and 3.
- R5: In a live 1-of-8 address, bit 0 equals count bit A and bit 1 equals count bit B.
- R6: In a live 4-input address, bit 0 equals count bit A. Count bit B has no effect on it, so count values 0 and 2 give the same address, and so do 1 and 3.
- R7: On a strobe, the result width becomes 8 in pulse mode and 10 in precision mode.
- R8: The power enable equals the converter-active input as it was one clock earlier.
- R9: The addresses and the result width change only on the clock edge that samples the strobe high. Input changes without a strobe leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_active | input | 1 | Converter is powered and converting |
| adv_strobe | input | 1 | Channel-advance pulse; captures new selection |
| mode_pulse | input | 1 | 1 = pulse-height mode, 0 = precision mode |
| det_sel | input | 1 | 1 = first 1-of-8 multiplexer live, 0 = second |
| cal | input | 1 | 1 = calibration points (lower address half) |
| cnt_a | input | 1 | Channel-count bit A |
| cnt_b | input | 1 | Channel-count bit B |
| oct0_addr | output | 3 | Address of the first 1-of-8 multiplexer |
| oct1_addr | output | 3 | Address of the second 1-of-8 multiplexer |
| quad_addr | output | 2 | Address of the 4-input multiplexer |
| res_bits | output | 4 | Number of reported result bits (8 or 10) |
| mux_pwr_en | output | 1 | Multiplexer power enable |

## Verification
A wrong routing decision shows on the address ports one clock after the strobe that caused it. The usual symptom is a second multiplexer left off address 0, which corrupts the summed input in a way that software cannot see. The bench therefore compares every address and the result width on the cycle after each strobe. It also compares them again after input changes made without a strobe, because a register that loads when it should hold only shows up there. An error in the power path appears on the enable one clock after converter-active changes.

// File: rtl/adc_mux_sel_pkg.sv
package adc_mux_sel_pkg;

  typedef enum logic {
    MODE_PRECISION = 1'b0,
    MODE_PULSE     = 1'b1
  } mux_mode_e;

  localparam int unsigned NUM_OCT = 2;

  // Detector-select high makes octet 0 live; low makes octet 1 live.
  function automatic logic [NUM_OCT-1:0] octet_live(input mux_mode_e mode,
                                                    input logic det);
    logic [NUM_OCT-1:0] v;
    v = '0;
    if (mode == MODE_PULSE) begin
      v[0] = det;
      v[1] = ~det;
    end
    return v;
  endfunction

endpackage

// File: rtl/adc_mux_sel_route.sv
module adc_mux_sel_route
  import adc_mux_sel_pkg::*;
(
  input  logic               mode_pulse,
  input  logic               det_sel,
  output logic [NUM_OCT-1:0] oct_live,
  output logic               quad_live
);

  mux_mode_e mode;

  always_comb begin
    mode      = mux_mode_e'(mode_pulse);
    oct_live  = octet_live(mode, det_sel);
    quad_live = (mode == MODE_PRECISION);
  end

endmodule

// File: rtl/adc_mux_sel_addr.sv
module adc_mux_sel_addr #(
  parameter int unsigned AW = 3,
  localparam int unsigned CW = AW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          live,
  input  logic          cal,
  input  logic [CW-1:0] cnt,
  output logic [AW-1:0] addr
);

  // A clamped multiplexer sits on address 0. A live one takes the
  // calibrate half in its top bit and the count in its low bits.
  function automatic logic [AW-1:0] next_addr(input logic l, input logic c,
                                              input logic [CW-1:0] n);
    return l ? {~c, n} : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= next_addr(live, cal, cnt);
  end

endmodule

// File: rtl/adc_mux_sel_stat.sv
module adc_mux_sel_stat #(
  parameter int unsigned RES_FULL = 10,
  parameter int unsigned RES_DROP = 2,
  localparam int unsigned RBW = $clog2(RES_FULL + 1),
  localparam int unsigned RES_PULSE = RES_FULL - RES_DROP
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           mode_pulse,
  input  logic           conv_active,
  output logic [RBW-1:0] res_bits,
  output logic           mux_pwr_en
);

  function automatic logic [RBW-1:0] width_for(input logic pulse);
    return pulse ? RBW'(RES_PULSE) : RBW'(RES_FULL);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_bits <= RBW'(RES_FULL);
    else if (load) res_bits <= width_for(mode_pulse);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mux_pwr_en <= 1'b0;
    else        mux_pwr_en <= conv_active;
  end

endmodule

// File: rtl/adc_mux_sel.sv
module adc_mux_sel
  import adc_mux_sel_pkg::*;
#(
  parameter int unsigned OCT_AW   = 3,
  parameter int unsigned QUAD_AW  = 2,
  parameter int unsigned RES_FULL = 10,
  parameter int unsigned RES_DROP = 2,
  localparam int unsigned RBW = $clog2(RES_FULL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               conv_active,
  input  logic               adv_strobe,
  input  logic               mode_pulse,
  input  logic               det_sel,
  input  logic               cal,
  input  logic               cnt_a,
  input  logic               cnt_b,
  output logic [OCT_AW-1:0]  oct0_addr,
  output logic [OCT_AW-1:0]  oct1_addr,
  output logic [QUAD_AW-1:0] quad_addr,
  output logic [RBW-1:0]     res_bits,
  output logic               mux_pwr_en
);

  logic               load_evt;
  logic [NUM_OCT-1:0] oct_live;
  logic               quad_live;
  logic [OCT_AW-1:0]  oct_addr [NUM_OCT];

  assign load_evt = adv_strobe;

  adc_mux_sel_route u_route (
    .mode_pulse (mode_pulse),
    .det_sel    (det_sel),
    .oct_live   (oct_live),
    .quad_live  (quad_live)
  );

  for (genvar g = 0; g < NUM_OCT; g++) begin : g_oct
    adc_mux_sel_addr #(.AW(OCT_AW)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_evt),
      .live  (oct_live[g]),
      .cal   (cal),
      .cnt   ({cnt_b, cnt_a}),
      .addr  (oct_addr[g])
    );
  end

  adc_mux_sel_addr #(.AW(QUAD_AW)) u_quad (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_evt),
    .live  (quad_live),
    .cal   (cal),
    .cnt   (cnt_a),
    .addr  (quad_addr)
  );

  adc_mux_sel_stat #(.RES_FULL(RES_FULL), .RES_DROP(RES_DROP)) u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load_evt),
    .mode_pulse  (mode_pulse),
    .conv_active (conv_active),
    .res_bits    (res_bits),
    .mux_pwr_en  (mux_pwr_en)
  );

  assign oct0_addr = oct_addr[0];
  assign oct1_addr = oct_addr[1];

endmodule

// File: rtl/adc_mux_sel_chk.sv
module adc_mux_sel_chk #(
  parameter int unsigned OCT_AW  = 3,
  parameter int unsigned QUAD_AW = 2,
  parameter int unsigned RBW     = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load_evt,
  input logic               conv_active,
  input logic               mode_pulse,
  input logic               det_sel,
  input logic               cal,
  input logic               cnt_a,
  input logic               cnt_b,
  input logic [OCT_AW-1:0]  oct0_addr,
  input logic [OCT_AW-1:0]  oct1_addr,
  input logic [QUAD_AW-1:0] quad_addr,
  input logic [RBW-1:0]     res_bits,
  input logic               mux_pwr_en
);

  AST_PULSE_QUAD_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && mode_pulse |=> quad_addr == '0); // R2

  AST_PULSE_DET_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && mode_pulse |=> (det_sel ? oct1_addr == '0 : oct0_addr == '0)); // R2

  AST_PREC_OCT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && !mode_pulse |=> oct0_addr == '0 && oct1_addr == '0); // R3

  AST_CAL_LOWER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && cal |=> !oct0_addr[OCT_AW-1] && !oct1_addr[OCT_AW-1]
                        && !quad_addr[QUAD_AW-1]); // R4

  AST_OCT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && mode_pulse && det_sel
      |=> oct0_addr[1:0] == {$past(cnt_b), $past(cnt_a)}); // R5

  AST_QUAD_A_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && !mode_pulse |=> quad_addr[0] == $past(cnt_a)); // R6

  AST_WIDTH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && mode_pulse |=> res_bits == RBW'(8)); // R7

  AST_PWR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> mux_pwr_en == $past(conv_active)); // R8

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(oct0_addr) && $stable(oct1_addr)
                  && $stable(quad_addr) && $stable(res_bits)); // R9

  AST_ONE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({|oct0_addr, |oct1_addr, |quad_addr}) <= 1); // R2

endmodule

bind adc_mux_sel adc_mux_sel_chk #(
  .OCT_AW(OCT_AW), .QUAD_AW(QUAD_AW), .RBW(RBW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .conv_active(conv_active),
  .mode_pulse(mode_pulse), .det_sel(det_sel), .cal(cal), .cnt_a(cnt_a),
  .cnt_b(cnt_b), .oct0_addr(oct0_addr), .oct1_addr(oct1_addr),
  .quad_addr(quad_addr), .res_bits(res_bits), .mux_pwr_en(mux_pwr_en)
);

// File: tb/sim_adc_mux_sel.sv
`timescale 1ns/1ps
module sim_adc_mux_sel;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_active = 1'b0, adv_strobe = 1'b0, mode_pulse = 1'b0;
  logic det_sel = 1'b0, cal = 1'b0, cnt_a = 1'b0, cnt_b = 1'b0;
  logic [2:0] oct0_addr, oct1_addr;
  logic [1:0] quad_addr;
  logic [3:0] res_bits;
  logic       mux_pwr_en;

  always #2 clk = ~clk;

  adc_mux_sel u0 (.*);

  typedef struct packed {
    logic [2:0] o0;
    logic [2:0] o1;
    logic [1:0] q;
    logic [3:0] w;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  int n_chk = 0, n_bad = 0;
  logic strobe_seen = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) strobe_seen <= adv_strobe;

  function automatic exp_t model(input bit pulse, input bit det, input bit c,
                                 input bit a, input bit b);
    exp_t e;
    int base;
    base = c ? 0 : 4;
    e = '0;
    if (pulse) begin
      e.w = 4'd8;
      if (det) e.o0 = 3'(base + 2 * b + a);
      else     e.o1 = 3'(base + 2 * b + a);
    end else begin
      e.w = 4'd10;
      e.q = 2'((c ? 0 : 2) + a);
    end
    return e;
  endfunction

  task automatic compare(input exp_t e, input string tag);
    exp_t act;
    act = '{o0: oct0_addr, o1: oct1_addr, q: quad_addr, w: res_bits};
    n_chk++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got o0=%0d o1=%0d q=%0d w=%0d exp o0=%0d o1=%0d q=%0d w=%0d",
               tag, act.o0, act.o1, act.q, act.w, e.o0, e.o1, e.q, e.w);
    end
  endtask

  // Monitor: pops one expected item on the cycle after each strobe.
  string cur_tag = "";
  always @(negedge clk) begin
    if (strobe_seen && exp_q.size() > 0) compare(exp_q.pop_front(), cur_tag);
  end

  // Driver: applies a selection with a one-cycle strobe, queues the expectation.
  task automatic drive(input bit pulse, input bit det, input bit c,
                       input bit a, input bit b, input string tag);
    @(negedge clk);
    mode_pulse = pulse; det_sel = det; cal = c; cnt_a = a; cnt_b = b;
    adv_strobe = 1'b1;
    cur_tag = tag;
    last_exp = model(pulse, det, c, a, b);
    exp_q.push_back(last_exp);
    @(negedge clk);
    adv_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_pwr(input bit exp_v, input string tag);
    n_chk++;
    if (mux_pwr_en !== exp_v) begin
      n_bad++;
      $display("FAIL %s: pwr got %0b exp %0b", tag, mux_pwr_en, exp_v);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    compare('{o0: 3'd0, o1: 3'd0, q: 2'd0, w: 4'd10}, "R1 reset addr/width");
    check_pwr(1'b0, "R1 reset power");
    rst_n = 1'b1;
    @(negedge clk);

    // R8: power enable lags converter-active by one clock
    conv_active = 1'b1;
    @(posedge clk); #1;
    check_pwr(1'b1, "R8 power on after one clock");
    @(negedge clk);
    conv_active = 1'b0;
    check_pwr(1'b1, "R8 power still on before edge");
    @(negedge clk);
    check_pwr(1'b0, "R8 power off");
    conv_active = 1'b1;

    // R2 R4 R5 R7: pulse mode, both detectors, full count sweep, both halves
    for (int c = 0; c < 2; c++)
      for (int d = 0; d < 2; d++)
        for (int n = 0; n < 4; n++)
          drive(1'b1, d[0], c[0], n[0], n[1], "R2/R4/R5/R7 pulse sweep");

    // R3 R6 R7: precision mode; detector-select ignored, B ignored on 4-input
    for (int c = 0; c < 2; c++)
      for (int d = 0; d < 2; d++)
        for (int n = 0; n < 4; n++)
          drive(1'b0, d[0], c[0], n[0], n[1], "R3/R6/R7 precision sweep");

    // R6: count values 2 and 0 give the same 4-input address
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6 B ignored cnt=2");
    compare('{o0: 3'd0, o1: 3'd0, q: 2'd2, w: 4'd10}, "R6 cnt2 equals cnt0");

    // R9: input changes without a strobe must not move the outputs
    @(negedge clk);
    mode_pulse = 1'b1; det_sel = 1'b1; cal = 1'b0; cnt_a = 1'b1; cnt_b = 1'b1;
    repeat (3) @(negedge clk);
    compare(last_exp, "R9 hold without strobe");
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R9 load after hold");
    compare('{o0: 3'd7, o1: 3'd0, q: 2'd0, w: 4'd8}, "R9/R5 loaded o0=7");

    // R1: reset clears loaded state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    compare('{o0: 3'd0, o1: 3'd0, q: 2'd0, w: 4'd10}, "R1 re-reset");
    check_pwr(1'b0, "R1 re-reset power");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule